// File: doc/BRIEF.md
# Indexed Palette RAMDAC Register Port

This block is the host-facing register port of a palette RAMDAC. It holds a 256-entry colour lookup table whose entries are 8-bit red, green and blue triples, plus four 8-bit control registers. The host sees a window of four 32-bit words and moves data only in the top byte of each word. To load a colour, the host writes a palette index to the address word and then makes three writes to the colour-map word, red first, then green, then blue. A two-bit component counter tracks the position in that sequence, and the address advances on its own after each blue, so a run of entries can be streamed without rewriting the address.

Control registers use the same address word. The host writes an index from 4 to 7 and then writes the value through the control word. Index 4 is the read mask. Index 5 is the blink mask, index 6 the command register and index 7 the test register. On the display side, a pixel index comes in every clock and is ANDed with the read mask. The RGB triple stored at the masked index comes out one clock later.

Top module: `pal_ramdac`

## Requirements
- R1: The word select is encoded 0 = address, 1 = colour map, 2 = control, 3 = cursor. Only bits 31:24 of a bus write are used. A read returns its byte in bits 31:24 with bits 23:0 zero, and bus_rdata is updated on the clock edge that samples bus_rd and holds until the next read.
- R2: A write to the address word loads the index from bits 31:24 and returns the component counter to red. A partly loaded triple is abandoned.
- R3: Colour-map writes go in the order red, green, blue. The entry at the current index is changed only by the blue write, which stores all three components together.
- R4: After the blue access, whether a write or a read, the address increments and the counter returns to red. Index 255 wraps to 0.
- R5: A colour-map read returns the component of the entry at the current index that the counter selects, and it advances the counter exactly as a write does.
- R6: A control-word write with the address at 4, 5, 6 or 7 stores the byte in that control register, and a control-word read at that address returns it.
- R7: A control-word write with the address outside 4..7 changes no control register, and a control-word read there returns 0.
- R8: After reset the address is 0, the counter is at red, the read mask (index 4) is 0xFF and the registers at indices 5, 6 and 7 are 0.
- R9: One clock after pix_idx is presented, pix_r/pix_g/pix_b show the palette entry at pix_idx AND read mask.
- R10: Cursor-word writes change neither the address nor the counter, and cursor-word reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_sel | input | 2 | Word select: 0 address, 1 colour map, 2 control, 3 cursor |
| bus_wdata | input | 32 | Write data; only bits 31:24 are used |
| bus_rdata | output | 32 | Registered read data in bits 31:24 |
| pix_idx | input | 8 | Pixel index from the display pipe |
| pix_r | output | 8 | Red component of the looked-up entry |
| pix_g | output | 8 | Green component of the looked-up entry |
| pix_b | output | 8 | Blue component of the looked-up entry |

## Verification
The assertions assume that bus_wr and bus_rd are never high in the same cycle, because the sequencer gives neither one priority and the counter checks expect a single advance per cycle. The bench drives every access through one write task or one read task. Each task raises exactly one strobe for a single cycle, and inputs change only on falling edges. Palette entries are looked up or read back only after the bench has written them, so no check depends on the contents of storage that was never initialised.

// File: rtl/pal_pkg.sv
package pal_pkg;

   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_CMAP = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_CURS = 2'd3
   } pal_sel_e;

   typedef enum logic [1:0] {
      COMP_RED = 2'd0,
      COMP_GRN = 2'd1,
      COMP_BLU = 2'd2,
      COMP_BAD = 2'd3
   } pal_comp_e;

endpackage

// File: rtl/pal_seq.sv
module pal_seq
   import pal_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  pal_sel_e          sel,
   input  logic [DATA_W-1:0] wbyte,
   output logic [IDX_W-1:0]  addr,
   output pal_comp_e         comp,
   output logic              cmap_hit
);

   assign cmap_hit = (wr || rd) && (sel == SEL_CMAP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr <= '0;
         comp <= COMP_RED;
      end else if (wr && sel == SEL_ADDR) begin
         addr <= wbyte[IDX_W-1:0];
         comp <= COMP_RED;
      end else if (cmap_hit) begin
         unique case (comp)
            COMP_RED: comp <= COMP_GRN;
            COMP_GRN: comp <= COMP_BLU;
            default: begin
               comp <= COMP_RED;
               addr <= addr + 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/pal_store.sv
module pal_store
   import pal_pkg::*;
#(
   parameter int ENTRIES    = 256,
   parameter int IDX_W      = 8,
   parameter int DATA_W     = 8,
   parameter bit LOOKUP_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmap_wr,
   input  pal_comp_e         comp,
   input  logic [IDX_W-1:0]  addr,
   input  logic [DATA_W-1:0] wbyte,
   input  logic [IDX_W-1:0]  pix_idx,
   input  logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] rd_byte,
   output logic [DATA_W-1:0] pix_r,
   output logic [DATA_W-1:0] pix_g,
   output logic [DATA_W-1:0] pix_b
);

   localparam int TRIPLE_W = 3 * DATA_W;

   logic [TRIPLE_W-1:0] mem [ENTRIES];
   logic [DATA_W-1:0]   r_hold;
   logic [DATA_W-1:0]   g_hold;
   logic [TRIPLE_W-1:0] host_entry;
   logic [IDX_W-1:0]    look_idx;
   logic [TRIPLE_W-1:0] look_entry;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r_hold <= '0;
         g_hold <= '0;
      end else if (cmap_wr) begin
         if (comp == COMP_RED) r_hold <= wbyte;
         if (comp == COMP_GRN) g_hold <= wbyte;
      end
   end

   always_ff @(posedge clk) begin
      if (cmap_wr && comp == COMP_BLU)
         mem[addr] <= {r_hold, g_hold, wbyte};
   end

   assign host_entry = mem[addr];

   always_comb begin
      unique case (comp)
         COMP_RED: rd_byte = host_entry[TRIPLE_W-1 -: DATA_W];
         COMP_GRN: rd_byte = host_entry[2*DATA_W-1 -: DATA_W];
         COMP_BLU: rd_byte = host_entry[DATA_W-1:0];
         default:  rd_byte = '0;
      endcase
   end

   assign look_idx   = pix_idx & mask[IDX_W-1:0];
   assign look_entry = mem[look_idx];

   generate
      if (LOOKUP_REG) begin : g_look_reg
         logic [TRIPLE_W-1:0] pix_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pix_q <= '0;
            else        pix_q <= look_entry;
         end
         assign {pix_r, pix_g, pix_b} = pix_q;
      end else begin : g_look_comb
         assign {pix_r, pix_g, pix_b} = look_entry;
      end
   endgenerate

endmodule

// File: rtl/pal_ctrl.sv
module pal_ctrl
   import pal_pkg::*;
#(
   parameter int          IDX_W     = 8,
   parameter int          DATA_W    = 8,
   parameter int          CTRL_BASE = 4,
   parameter int          CTRL_NUM  = 4,
   parameter logic [7:0]  MASK_RST  = 8'hFF
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr,
   input  pal_sel_e                   sel,
   input  logic [IDX_W-1:0]           addr,
   input  logic [DATA_W-1:0]          wbyte,
   output logic [DATA_W-1:0]          rd_byte,
   output logic [DATA_W-1:0]          mask,
   output logic [CTRL_NUM*DATA_W-1:0] ctrl_flat
);

   logic [DATA_W-1:0] regs [CTRL_NUM];

   genvar g;
   generate
      for (g = 0; g < CTRL_NUM; g++) begin : g_reg
         localparam logic [DATA_W-1:0] RST_V = (g == 0) ? DATA_W'(MASK_RST) : '0;
         always_ff @(posedge clk) begin
            if (!rst_n)
               regs[g] <= RST_V;
            else if (wr && sel == SEL_CTRL && addr == IDX_W'(CTRL_BASE + g))
               regs[g] <= wbyte;
         end
         assign ctrl_flat[g*DATA_W +: DATA_W] = regs[g];
      end
   endgenerate

   always_comb begin
      rd_byte = '0;
      for (int i = 0; i < CTRL_NUM; i++) begin
         if (addr == IDX_W'(CTRL_BASE + i)) rd_byte = regs[i];
      end
   end

   assign mask = regs[0];

endmodule

// File: rtl/pal_ramdac.sv
module pal_ramdac
   import pal_pkg::*;
#(
   parameter int ENTRIES    = 256,
   parameter int DATA_W     = 8,
   parameter int BUS_W      = 32,
   parameter int CTRL_BASE  = 4,
   parameter int CTRL_NUM   = 4,
   parameter bit LOOKUP_REG = 1'b1,
   localparam int IDX_W     = $clog2(ENTRIES),
   localparam int LANE_LSB  = BUS_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_sel,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [IDX_W-1:0]  pix_idx,
   output logic [DATA_W-1:0] pix_r,
   output logic [DATA_W-1:0] pix_g,
   output logic [DATA_W-1:0] pix_b
);

   initial begin
      assert (ENTRIES == (1 << IDX_W)) else $fatal(1, "ENTRIES must be a power of two");
      assert (IDX_W <= DATA_W) else $fatal(1, "index wider than data byte");
      assert (BUS_W > DATA_W) else $fatal(1, "bus must be wider than data lane");
      assert (CTRL_BASE + CTRL_NUM <= ENTRIES) else $fatal(1, "control window out of range");
   end

   pal_sel_e                   sel;
   logic [DATA_W-1:0]          wbyte;
   logic                       unused_lane;
   logic [IDX_W-1:0]           addr_q;
   pal_comp_e                  comp_q;
   logic                       cmap_hit;
   logic [DATA_W-1:0]          cmap_byte;
   logic [DATA_W-1:0]          ctrl_byte;
   logic [DATA_W-1:0]          rmask;
   logic [CTRL_NUM*DATA_W-1:0] ctrl_flat;
   logic [DATA_W-1:0]          rd_mux;

   assign sel         = pal_sel_e'(bus_sel);
   assign wbyte       = bus_wdata[BUS_W-1 -: DATA_W];
   assign unused_lane = ^bus_wdata[LANE_LSB-1:0];

   pal_seq #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .sel(sel),
      .wbyte(wbyte), .addr(addr_q), .comp(comp_q), .cmap_hit(cmap_hit)
   );

   pal_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .DATA_W(DATA_W),
               .LOOKUP_REG(LOOKUP_REG)) u_store (
      .clk(clk), .rst_n(rst_n), .cmap_wr(cmap_hit && bus_wr), .comp(comp_q),
      .addr(addr_q), .wbyte(wbyte), .pix_idx(pix_idx), .mask(rmask),
      .rd_byte(cmap_byte), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
   );

   pal_ctrl #(.IDX_W(IDX_W), .DATA_W(DATA_W), .CTRL_BASE(CTRL_BASE),
              .CTRL_NUM(CTRL_NUM)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(sel), .addr(addr_q),
      .wbyte(wbyte), .rd_byte(ctrl_byte), .mask(rmask), .ctrl_flat(ctrl_flat)
   );

   always_comb begin
      unique case (sel)
         SEL_ADDR: rd_mux = DATA_W'(addr_q);
         SEL_CMAP: rd_mux = cmap_byte;
         SEL_CTRL: rd_mux = ctrl_byte;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= {rd_mux, {LANE_LSB{1'b0}}};
   end

endmodule

// File: rtl/pal_ramdac_chk.sv
module pal_ramdac_chk #(
   parameter int IDX_W     = 8,
   parameter int DATA_W    = 8,
   parameter int BUS_W     = 32,
   parameter int CTRL_BASE = 4,
   parameter int CTRL_NUM  = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       bus_wr,
   input logic                       bus_rd,
   input logic [1:0]                 bus_sel,
   input logic [BUS_W-1:0]           bus_wdata,
   input logic [BUS_W-1:0]           bus_rdata,
   input logic [IDX_W-1:0]           addr_q,
   input logic [1:0]                 comp_q,
   input logic [CTRL_NUM*DATA_W-1:0] ctrl_flat
);

   localparam int LANE_LSB = BUS_W - DATA_W;

   logic ctrl_out_of_range;
   assign ctrl_out_of_range = (int'(addr_q) < CTRL_BASE) ||
                              (int'(addr_q) >= CTRL_BASE + CTRL_NUM);

   // R1
   lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[LANE_LSB-1:0] == '0);

   // R2
   addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel == 2'd0) |=>
         (addr_q == $past(bus_wdata[BUS_W-1 -: IDX_W])) && (comp_q == 2'd0));

   // R4
   blue_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_wr || bus_rd) && bus_sel == 2'd1 && comp_q == 2'd2) |=>
         (addr_q == IDX_W'($past(addr_q) + 1'b1)) && (comp_q == 2'd0));

   // R5
   comp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_wr || bus_rd) && bus_sel == 2'd1 && comp_q != 2'd2) |=>
         (comp_q == 2'($past(comp_q) + 1'b1)) && $stable(addr_q));

   // R5
   comp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      comp_q != 2'd3);

   // R7
   ctrl_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel == 2'd2 && ctrl_out_of_range) |=> $stable(ctrl_flat));

   // R10
   cursor_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel == 2'd3) |=> $stable(addr_q) && $stable(comp_q));

endmodule

bind pal_ramdac pal_ramdac_chk #(
   .IDX_W(IDX_W), .DATA_W(DATA_W), .BUS_W(BUS_W),
   .CTRL_BASE(CTRL_BASE), .CTRL_NUM(CTRL_NUM)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .addr_q(addr_q), .comp_q(comp_q), .ctrl_flat(ctrl_flat)
);

// File: tb/test_pal_ramdac.sv
module test_pal_ramdac;

   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [1:0]  bus_sel = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  pix_idx = '0;
   logic [7:0]  pix_r, pix_g, pix_b;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pal_ramdac i_pal_ramdac (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pix_idx(pix_idx), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_word(input logic [1:0] s, input logic [31:0] w);
      @(negedge clk);
      bus_sel = s; bus_wdata = w; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic wr_byte(input logic [1:0] s, input logic [7:0] b);
      wr_word(s, {b, 24'h5A5A5A});
   endtask

   task automatic rd_word(input logic [1:0] s, output logic [31:0] w);
      @(negedge clk);
      bus_sel = s; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      w = bus_rdata;
   endtask

   task automatic load_rgb(input logic [7:0] idx, input logic [7:0] r,
                           input logic [7:0] g, input logic [7:0] b);
      wr_byte(2'd0, idx);
      wr_byte(2'd1, r);
      wr_byte(2'd1, g);
      wr_byte(2'd1, b);
   endtask

   task automatic look(input logic [7:0] idx, output logic [23:0] rgb);
      @(negedge clk);
      pix_idx = idx;
      @(negedge clk);
      rgb = {pix_r, pix_g, pix_b};
   endtask

   task automatic ctrl_read(input logic [7:0] idx, output logic [31:0] w);
      wr_byte(2'd0, idx);
      rd_word(2'd2, w);
   endtask

   task automatic t_reset();
      logic [31:0] w;
      rd_word(2'd0, w);
      check("R8 address after reset", w, 32'h0);
      ctrl_read(8'd4, w);
      check("R8 read mask after reset", w, 32'hFF00_0000);
      ctrl_read(8'd6, w);
      check("R8 command after reset", w, 32'h0);
      ctrl_read(8'd7, w);
      check("R8 test reg after reset", w, 32'h0);
   endtask

   task automatic t_lane();
      logic [31:0] w;
      wr_word(2'd0, 32'h12AB_CDEF);
      rd_word(2'd0, w);
      check("R1 lane: addr from top byte, low bits zero", w, 32'h1200_0000);
   endtask

   task automatic t_commit();
      logic [23:0] rgb;
      load_rgb(8'd10, 8'h01, 8'h02, 8'h03);
      look(8'd10, rgb);
      check("R3 first triple stored", {8'h0, rgb}, 32'h0001_0203);
      wr_byte(2'd0, 8'd10);
      wr_byte(2'd1, 8'h11);
      wr_byte(2'd1, 8'h22);
      look(8'd10, rgb);
      check("R3 entry unchanged before blue", {8'h0, rgb}, 32'h0001_0203);
      wr_byte(2'd1, 8'h33);
      look(8'd10, rgb);
      check("R3 entry after blue write", {8'h0, rgb}, 32'h0011_2233);
   endtask

   task automatic t_autoinc();
      logic [31:0] w;
      logic [23:0] rgb;
      rd_word(2'd0, w);
      check("R4 address advanced after blue", w, 32'h0B00_0000);
      wr_byte(2'd1, 8'h44);
      wr_byte(2'd1, 8'h55);
      wr_byte(2'd1, 8'h66);
      look(8'd11, rgb);
      check("R4 streamed entry lands at next index", {8'h0, rgb}, 32'h0044_5566);
      load_rgb(8'd255, 8'hA1, 8'hA2, 8'hA3);
      rd_word(2'd0, w);
      check("R4 address wraps 255 to 0", w, 32'h0);
      look(8'd255, rgb);
      check("R4 entry 255 stored", {8'h0, rgb}, 32'h00A1_A2A3);
   endtask

   task automatic t_restart();
      logic [23:0] rgb;
      logic [31:0] w;
      wr_byte(2'd0, 8'd20);
      wr_byte(2'd1, 8'hEE);
      load_rgb(8'd20, 8'h07, 8'h08, 8'h09);
      look(8'd20, rgb);
      check("R2 address write restarts at red", {8'h0, rgb}, 32'h0007_0809);
      rd_word(2'd0, w);
      check("R2 address after restarted triple", w, 32'h1500_0000);
   endtask

   task automatic t_readback();
      logic [31:0] w;
      wr_byte(2'd0, 8'd10);
      rd_word(2'd1, w);
      check("R5 read red", w, 32'h1100_0000);
      rd_word(2'd1, w);
      check("R5 read green", w, 32'h2200_0000);
      rd_word(2'd1, w);
      check("R5 read blue", w, 32'h3300_0000);
      rd_word(2'd0, w);
      check("R4 address advanced after blue read", w, 32'h0B00_0000);
      rd_word(2'd1, w);
      check("R5 read continues at next entry", w, 32'h4400_0000);
   endtask

   task automatic t_ctrl();
      logic [31:0] w;
      wr_byte(2'd0, 8'd5);
      wr_byte(2'd2, 8'h5A);
      rd_word(2'd2, w);
      check("R6 blink mask write/read", w, 32'h5A00_0000);
      wr_byte(2'd0, 8'd7);
      wr_byte(2'd2, 8'hC3);
      rd_word(2'd2, w);
      check("R6 test reg write/read", w, 32'hC300_0000);
      wr_byte(2'd0, 8'd6);
      wr_byte(2'd2, 8'h73);
      rd_word(2'd2, w);
      check("R6 command write/read", w, 32'h7300_0000);
   endtask

   task automatic t_ctrl_ignore();
      logic [31:0] w;
      wr_byte(2'd0, 8'd3);
      wr_byte(2'd2, 8'h99);
      rd_word(2'd2, w);
      check("R7 read at index 3 is zero", w, 32'h0);
      wr_byte(2'd0, 8'd8);
      wr_byte(2'd2, 8'h99);
      rd_word(2'd2, w);
      check("R7 read at index 8 is zero", w, 32'h0);
      ctrl_read(8'd4, w);
      check("R7 read mask untouched", w, 32'hFF00_0000);
      ctrl_read(8'd5, w);
      check("R7 blink mask untouched", w, 32'h5A00_0000);
      ctrl_read(8'd6, w);
      check("R7 command untouched", w, 32'h7300_0000);
      ctrl_read(8'd7, w);
      check("R7 test reg untouched", w, 32'hC300_0000);
   endtask

   task automatic t_lookup();
      logic [23:0] rgb;
      look(8'd11, rgb);
      check("R9 lookup with full mask", {8'h0, rgb}, 32'h0044_5566);
      wr_byte(2'd0, 8'd4);
      wr_byte(2'd2, 8'h0F);
      look(8'h1A, rgb);
      check("R9 masked index 0x1A reads entry 10", {8'h0, rgb}, 32'h0011_2233);
      look(8'hFB, rgb);
      check("R9 masked index 0xFB reads entry 11", {8'h0, rgb}, 32'h0044_5566);
      wr_byte(2'd0, 8'd4);
      wr_byte(2'd2, 8'hFF);
      look(8'hFF, rgb);
      check("R9 mask restored reads entry 255", {8'h0, rgb}, 32'h00A1_A2A3);
   endtask

   task automatic t_cursor();
      logic [31:0] w;
      logic [23:0] rgb;
      wr_byte(2'd0, 8'd30);
      wr_byte(2'd1, 8'h31);
      wr_byte(2'd3, 8'h77);
      rd_word(2'd0, w);
      check("R10 cursor write leaves address", w, 32'h1E00_0000);
      rd_word(2'd3, w);
      check("R10 cursor read is zero", w, 32'h0);
      wr_byte(2'd1, 8'h32);
      wr_byte(2'd1, 8'h33);
      look(8'd30, rgb);
      check("R10 counter kept across cursor access", {8'h0, rgb}, 32'h0031_3233);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_lane();
      t_commit();
      t_autoinc();
      t_restart();
      t_readback();
      t_ctrl();
      t_ctrl_ignore();
      t_lookup();
      t_cursor();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule